// File: doc/BRIEF.md
# Fractional clock divider generator

This block derives an output clock from an input clock by dividing it by a programmable fixed-point divisor. The divisor has a 16-bit whole part and a 16-bit fractional part. The generator is built around a four-state machine: `ST_OFF`, `ST_HIGH`, `ST_LOW` and `ST_PASS`. Each output period starts in `ST_HIGH` and finishes in `ST_LOW`. For each new period, a fraction accumulator decides whether that period is stretched by one input cycle. Over many periods this gives an average period of whole plus fraction input cycles. A whole divisor of 1 selects `ST_PASS`, which routes the input clock straight to the output through a gate that only changes while the input clock is low.

The generator is started and stopped with a level enable. The enable can first pass through a selectable delay of 0 to 3 input cycles. A stop request always lets the current output period finish. A kill input stops the generator at once, asynchronously. After a kill, the generator does not restart until the enable has been seen low. Each toggle of a nudge input holds the period counter for one cycle, which moves the output phase by one input cycle. When duty-cycle correction is on and the period is odd, a falling-edge register stretches the high phase by half an input cycle, so the high and low times are equal. A status output reports whether the generator is actually running.

State transitions:
- `ST_OFF -> ST_HIGH`: the delayed enable is seen, no restart lock is held, and the whole divisor is not 1. A new period is loaded at this point.
- `ST_OFF -> ST_PASS`: the same conditions hold, but the whole divisor is 1.
- `ST_HIGH -> ST_LOW`: the counter reaches half the period, rounded down. A nudge holds the state for one cycle.
- `ST_LOW -> ST_HIGH`: the period ends and the enable is still present. A new period is loaded.
- `ST_LOW -> ST_PASS`: the period ends and the whole divisor is now 1.
- `ST_LOW -> ST_OFF`: the period ends and the enable has gone.
- `ST_PASS -> ST_OFF`: the enable has gone or the whole divisor is no longer 1.
- Any state goes to `ST_OFF` asynchronously on kill or reset.

Top module: `clkdiv_frac_gen`

## Requirements
- R1: While reset is applied and just after it, `clk_out` is 0 and `status_running` is 0.
- R2: With the fraction at 0 and a whole divisor N of 2 or more, the output period is N input cycles. The output is high for floor(N/2) cycles and then low for the rest. A whole divisor of 0 means 65536.
- R3: With `cfg_dc50`=1 and an odd period, the output is high for N/2 input cycles, which includes half a cycle. Example: N=5 gives 2.5 cycles high.
- R4: Each new period adds `div_frac` to a 16-bit accumulator. A carry out of the accumulator adds one input cycle to that period. The fraction is read at each period start, so it can be changed while the clock runs. Example: 0x8000 makes the periods alternate between N and N+1.
- R5: A whole divisor of 1 passes the input clock to `clk_out` (high 1/2 cycle, period 1 cycle). `div_frac` has no effect in this case.
- R6: Starting begins with a full high phase. Clearing `cfg_enable` lets the current period finish, after which the output stays low.
- R7: `cfg_kill`=1 forces `clk_out` and `status_running` to 0 without waiting for a clock edge. After a kill, the generator stays stopped while `cfg_enable` stays high. It starts again only after `cfg_enable` has been seen low and then set.
- R8: With `cfg_phase`=p, the first output rising edge after the enable is set comes p input cycles later than with p=0. With p=0 it comes on the first input rising edge.
- R9: Each change of level on `cfg_nudge` holds the period counter for one input cycle. The output period in progress therefore grows by one input cycle.
- R10: `status_running` is 1 from the start edge until the generator returns to the stopped state, including the final low phase after a stop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Level start/stop request |
| cfg_kill | input | 1 | Asynchronous stop, active high |
| cfg_phase | input | PHASE_W | Enable delay in input cycles |
| cfg_nudge | input | 1 | Each level change shifts phase by one cycle |
| cfg_dc50 | input | 1 | Equal high and low time for odd periods |
| div_int | input | INT_W | Whole part of divisor, 0 means 2^INT_W |
| div_frac | input | FRAC_W | Fractional part of divisor |
| clk_out | output | 1 | Divided clock |
| status_running | output | 1 | Generator is running |

## Verification
The assertions assume two things about the inputs. First, a kill is held across at least one input rising edge. Second, a nudge toggle or an enable change is an input-domain level that persists for at least a cycle, so the state machine and the counter can be related edge by edge. The stimulus drives every control input on the input clock's falling edge. It changes the phase and duty controls only while the generator is stopped with the enable pipeline flushed. It changes the fraction only while running and then skips two periods before measuring.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_PASS = 2'd3
    } gen_state_e;

endpackage

// File: rtl/clkdiv_phase_delay.sv
module clkdiv_phase_delay #(
    parameter int PHASE_W = 2
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic               en_req,
    input  logic [PHASE_W-1:0] phase_sel,
    output logic               en_dly
);
    localparam int DEPTH = (1 << PHASE_W) - 1;

    logic [DEPTH-1:0] pipe;
    logic [DEPTH:0]   taps;

    // one flop per stage of enable delay
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk_in or negedge rst_n) begin
                if (!rst_n) pipe[0] <= 1'b0;
                else        pipe[0] <= en_req;
            end
        end else begin : g_next
            always_ff @(posedge clk_in or negedge rst_n) begin
                if (!rst_n) pipe[i] <= 1'b0;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign taps   = {pipe, en_req};
    assign en_dly = taps[phase_sel];
endmodule

// File: rtl/clkdiv_period_calc.sv
module clkdiv_period_calc #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic             clk_in,
    input  logic             hard_stop,
    input  logic             load,
    input  logic [INT_W-1:0] div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic [INT_W:0]   period_next
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] acc_sum;
    logic              carry;
    logic [INT_W:0]    eff_int;

    assign {carry, acc_sum} = {1'b0, acc} + {1'b0, div_frac};
    assign eff_int = (div_int == '0) ? {1'b1, {INT_W{1'b0}}} : {1'b0, div_int};
    assign period_next = eff_int + {{INT_W{1'b0}}, carry};

    always_ff @(posedge clk_in or posedge hard_stop) begin
        if (hard_stop)  acc <= '0;
        else if (load)  acc <= acc_sum;
    end
endmodule

// File: rtl/clkdiv_frac_gen.sv
module clkdiv_frac_gen
    import clkdiv_pkg::*;
#(
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 16,
    parameter int PHASE_W = 2
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_kill,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic               cfg_nudge,
    input  logic               cfg_dc50,
    input  logic [INT_W-1:0]   div_int,
    input  logic [FRAC_W-1:0]  div_frac,
    output logic               clk_out,
    output logic               status_running
);
    localparam int CNT_W = INT_W + 1;

    gen_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, per, half, period_next;
    logic             hard_stop, restart_lock, en_dly, go;
    logic             nudge_q, stall, int_is_one, reload;
    logic             dco_q, hi_q, ext_n, gate_n;

    assign hard_stop  = cfg_kill | ~rst_n;
    assign int_is_one = (div_int == INT_W'(1));
    assign half       = per >> 1;
    assign stall      = cfg_nudge ^ nudge_q;
    assign go         = en_dly & ~restart_lock;

    // kill sets the lock; only a low enable clears it
    always_ff @(posedge clk_in or negedge rst_n or posedge cfg_kill) begin
        if (!rst_n)           restart_lock <= 1'b0;
        else if (cfg_kill)    restart_lock <= 1'b1;
        else if (!cfg_enable) restart_lock <= 1'b0;
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) nudge_q <= 1'b0;
        else        nudge_q <= cfg_nudge;
    end

    clkdiv_phase_delay #(.PHASE_W(PHASE_W)) u_phase (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .en_req    (cfg_enable),
        .phase_sel (cfg_phase),
        .en_dly    (en_dly)
    );

    clkdiv_period_calc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
        .clk_in      (clk_in),
        .hard_stop   (hard_stop),
        .load        (reload),
        .div_int     (div_int),
        .div_frac    (div_frac),
        .period_next (period_next)
    );

    // next state and period-load decision
    always_comb begin
        state_nx = state;
        reload   = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (go) begin
                    if (int_is_one) begin
                        state_nx = ST_PASS;
                    end else begin
                        state_nx = ST_HIGH;
                        reload   = 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (!stall && cnt == half - CNT_W'(1)) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (!stall && cnt == per - CNT_W'(1)) begin
                    if (!go) begin
                        state_nx = ST_OFF;
                    end else if (int_is_one) begin
                        state_nx = ST_PASS;
                    end else begin
                        state_nx = ST_HIGH;
                        reload   = 1'b1;
                    end
                end
            end
            ST_PASS: begin
                if (!go || !int_is_one) state_nx = ST_OFF;
            end
        endcase
    end

    // state register with period counter
    always_ff @(posedge clk_in or posedge hard_stop) begin
        if (hard_stop) begin
            state <= ST_OFF;
            cnt   <= '0;
            per   <= '0;
            dco_q <= 1'b0;
            hi_q  <= 1'b0;
        end else begin
            state <= state_nx;
            hi_q  <= (state_nx == ST_HIGH);
            if (reload) begin
                cnt   <= '0;
                per   <= period_next;
                dco_q <= cfg_dc50 & period_next[0];
            end else if ((state == ST_HIGH || state == ST_LOW) && !stall) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // outputs: falling-edge stretch and pass-through gate
    always_ff @(negedge clk_in or posedge hard_stop) begin
        if (hard_stop) begin
            ext_n  <= 1'b0;
            gate_n <= 1'b0;
        end else begin
            ext_n  <= hi_q & dco_q;
            gate_n <= (state == ST_PASS);
        end
    end

    assign clk_out        = hi_q | ext_n | (clk_in & gate_n);
    assign status_running = (state != ST_OFF);
endmodule

// File: rtl/clkdiv_frac_gen_chk.sv
module clkdiv_frac_gen_chk
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             cfg_kill,
    input logic             status_running,
    input gen_state_e       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per,
    input logic             stall
);
    AST_KILL_HALTS: assert property (@(posedge clk_in) disable iff (!rst_n)
        cfg_kill |-> !status_running); // R7

    AST_KILL_LOCKS: assert property (@(posedge clk_in) disable iff (!rst_n)
        $past(cfg_kill) |-> !status_running); // R7

    AST_HIGH_WINDOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        state == ST_HIGH |-> cnt < (per >> 1)); // R2

    AST_LOW_WINDOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        state == ST_LOW |-> (cnt >= (per >> 1)) && (cnt < per)); // R2

    AST_NUDGE_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n || cfg_kill)
        stall && (state == ST_HIGH || state == ST_LOW) |=> cnt == $past(cnt)); // R9

    AST_CLEAN_STOP: assert property (@(posedge clk_in) disable iff (!rst_n || cfg_kill)
        $fell(status_running) && !$past(cfg_kill)
            |-> ($past(state) == ST_LOW || $past(state) == ST_PASS)); // R6
endmodule

bind clkdiv_frac_gen clkdiv_frac_gen_chk #(.CNT_W(INT_W + 1)) u_chk (
    .clk_in         (clk_in),
    .rst_n          (rst_n),
    .cfg_kill       (cfg_kill),
    .status_running (status_running),
    .state          (state),
    .cnt            (cnt),
    .per            (per),
    .stall          (stall)
);

// File: tb/clkdiv_frac_gen_bench.sv
`timescale 1ns/1ps
module clkdiv_frac_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, kill = 1'b0, nudge = 1'b0, dc50 = 1'b0;
    logic [1:0]  phase = 2'd0;
    logic [15:0] dint = 16'd4, dfrac = 16'd0;
    logic        clk_out, running;
    int          checks = 0, fails = 0, rise_cnt = 0;

    always #2 clk = ~clk;

    clkdiv_frac_gen u_clkdiv_frac_gen (
        .clk_in(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_kill(kill),
        .cfg_phase(phase), .cfg_nudge(nudge), .cfg_dc50(dc50),
        .div_int(dint), .div_frac(dfrac),
        .clk_out(clk_out), .status_running(running)
    );

    always @(posedge clk_out) rise_cnt++;

    task automatic check_eq(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ns(realtime d);
        return longint'($rtoi(d + 0.5));
    endfunction

    task automatic measure(output longint hi, output longint per);
        realtime a, b, c;
        @(posedge clk_out); a = $realtime;
        @(negedge clk_out); b = $realtime;
        @(posedge clk_out); c = $realtime;
        hi = ns(b - a); per = ns(c - a);
    endtask

    task automatic span(input int n, output longint tot);
        realtime a;
        @(posedge clk_out); a = $realtime;
        repeat (n) @(posedge clk_out);
        tot = ns($realtime - a);
    endtask

    task automatic start_gen(input logic [15:0] i, input logic [15:0] f, input logic d);
        @(negedge clk);
        dint = i; dfrac = f; dc50 = d; en = 1'b1;
    endtask

    task automatic stop_gen();
        @(negedge clk); en = 1'b0;
        for (int k = 0; k < 70000 && running; k++) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_eq("R1 clk_out in reset", clk_out, 0);
        check_eq("R1 running in reset", running, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1 running after reset", running, 0);
    endtask

    task automatic t_even_odd();
        longint hi, per;
        start_gen(16'd4, 16'd0, 1'b0);
        measure(hi, per);
        check_eq("R2 high N=4", hi, 8);
        check_eq("R2 period N=4", per, 16);
        #1 check_eq("R10 running while on", running, 1);
        stop_gen();
        start_gen(16'd5, 16'd0, 1'b0);
        measure(hi, per);
        check_eq("R2 high N=5", hi, 8);
        check_eq("R2 period N=5", per, 20);
        stop_gen();
    endtask

    task automatic t_dc50();
        longint hi, per;
        start_gen(16'd5, 16'd0, 1'b1);
        measure(hi, per);
        check_eq("R3 high N=5 dc50", hi, 10);
        check_eq("R3 period N=5 dc50", per, 20);
        stop_gen();
        start_gen(16'd3, 16'd0, 1'b1);
        measure(hi, per);
        check_eq("R3 high N=3 dc50", hi, 6);
        check_eq("R3 period N=3 dc50", per, 12);
        stop_gen();
    endtask

    task automatic t_frac();
        longint tot;
        start_gen(16'd4, 16'h8000, 1'b0);
        repeat (2) @(posedge clk_out);
        span(2, tot);
        check_eq("R4 two periods frac 1/2", tot, 36);
        @(negedge clk); dfrac = 16'h4000;
        repeat (2) @(posedge clk_out);
        span(4, tot);
        check_eq("R4 four periods frac 1/4 on the fly", tot, 68);
        stop_gen();
    endtask

    task automatic t_pass();
        longint hi, per;
        start_gen(16'd1, 16'h1234, 1'b0);
        measure(hi, per);
        check_eq("R5 pass high", hi, 2);
        check_eq("R5 pass period", per, 4);
        stop_gen();
    endtask

    task automatic t_max();
        longint hi, per;
        realtime a;
        start_gen(16'd0, 16'd0, 1'b0);
        @(posedge clk_out); a = $realtime;
        @(negedge clk_out);
        hi = ns($realtime - a);
        check_eq("R2 high with divisor 0 (65536)", hi, 131072);
        stop_gen();
        per = 0;
    endtask

    task automatic t_phase(input logic [1:0] p);
        realtime a, b;
        phase = p;
        @(negedge clk); a = $realtime; dint = 16'd4; dfrac = 0; dc50 = 0; en = 1'b1;
        @(posedge clk_out); b = $realtime;
        check_eq($sformatf("R8 first rise delay phase %0d", p), ns(b - a), 2 + 4 * p);
        @(negedge clk_out);
        check_eq("R6 first high is full", ns($realtime - b), 8);
        stop_gen();
        phase = 2'd0;
    endtask

    task automatic t_clean_stop();
        realtime a;
        int r0;
        start_gen(16'd4, 16'd0, 1'b0);
        @(posedge clk_out); a = $realtime;
        @(negedge clk); en = 1'b0;
        @(negedge clk_out);
        check_eq("R6 high kept full after disable", ns($realtime - a), 8);
        #1 check_eq("R10 running through last low", running, 1);
        r0 = rise_cnt;
        repeat (12) @(negedge clk);
        check_eq("R6 no pulse after stop", rise_cnt, r0);
        check_eq("R10 running cleared after stop", running, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_kill();
        int r0;
        start_gen(16'd4, 16'd0, 1'b0);
        @(posedge clk_out);
        #1 kill = 1'b1;
        #0.5;
        check_eq("R7 clk_out forced low", clk_out, 0);
        check_eq("R7 running forced low", running, 0);
        repeat (3) @(negedge clk);
        kill = 1'b0;
        r0 = rise_cnt;
        repeat (20) @(negedge clk);
        check_eq("R7 no restart with enable held", rise_cnt, r0);
        check_eq("R7 still stopped", running, 0);
        en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R7 restarts after enable low", running, 1);
        stop_gen();
    endtask

    task automatic t_nudge();
        realtime a, b, c;
        longint hi, per;
        start_gen(16'd4, 16'd0, 1'b0);
        measure(hi, per);
        for (int k = 0; k < 2; k++) begin
            @(posedge clk_out); a = $realtime;
            @(negedge clk); nudge = ~nudge;
            @(posedge clk_out); b = $realtime;
            @(posedge clk_out); c = $realtime;
            check_eq("R9 nudged period", ns(b - a), 20);
            check_eq("R9 following period", ns(c - b), 16);
        end
        stop_gen();
    endtask

    initial begin
        t_reset();
        t_even_odd();
        t_dc50();
        t_frac();
        t_pass();
        t_phase(2'd0);
        t_phase(2'd2);
        t_phase(2'd3);
        t_clean_stop();
        t_kill();
        t_nudge();
        t_max();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule